// File: doc/BRIEF.md
# Three-Address I2C Slave Status Tracker

This block is the bus-facing half of an I2C slave that answers to three independent 7-bit addresses. It oversamples SCL and SDA with the system clock and finds Start, Stop and repeated-Start conditions. It shifts in the address byte and acknowledges it when the address matches one of the three configured values. For read transfers it serializes a byte supplied by the surrounding buffer logic. Each address has its own read-event flag and write-event flag. Bus errors and a master not-acknowledge that is left dangling are also flagged, all in one 8-bit status word.

After a write transfer ends, the block locks itself: every later address byte gets no acknowledge until software releases the lock through a 2-bit control word. The same control word selects byte or word buffer updates. In word mode the lock is also released by hardware once two buffer byte writes have been made, so a 16-bit value is never seen half-updated.

Software reads the status word through a small register port. Error flags clear when the status is read. Event flags clear on a read only while the bus is idle.

Top module: `tri_addr_i2c_slave`

## Requirements
- R1: After reset the status word reads 00h, the control word reads 00h and `sda_pull` is low.
- R2: An address byte (7-bit address MSB first, then a direction bit, 1 = read) that equals `addr_1`, `addr_2` or `addr_3` is acknowledged, and so is every data byte written after it. Any other address gets no acknowledge and sets no flag.
- R3: The status word is, from bit 7 down to bit 0: dangling-NACK, bus error, write-3, write-2, write-1, read-3, read-2, read-1. An acknowledged address sets the write flag or the read flag of the matching slot, according to the direction bit.
- R4: A status read (`reg_rd` with `reg_sel`=0) returns the current status. It clears both error bits. It clears the six event bits only if no Start is outstanding, that is, outside any Start…Stop span.
- R5: A Stop or repeated Start that follows an acknowledged write address sets the lock flag (control bit 1). While the lock flag is set, address bytes are not acknowledged and set no flag. A transfer that was only a read does not set the lock flag.
- R6: A control write (`reg_wr` with `reg_sel`=1) whose bit 0 differs from the current mode stores the new mode and sets the lock flag. Otherwise bit 1 = 0 clears the lock flag and bit 1 = 1 leaves it unchanged. A write with `reg_sel`=0 changes nothing.
- R7: In word mode (control bit 0 = 1), the second `buf_wr` pulse after the lock flag was set clears the lock flag. In byte mode `buf_wr` has no effect on it.
- R8: The dangling-NACK bit is set when the master answers a read byte with not-acknowledge and then completes a further SCL clock pulse without a Stop or Start. A Stop right after the not-acknowledge leaves the bit clear.
- R9: A Start or Stop that arrives after two or more bits of an address or data byte have been clocked sets the bus-error bit.
- R10: While `en` is low the status word is cleared and kept at 00h, and no address is acknowledged. The lock flag and the mode are kept.
- R11: In a read transfer the slave sends `tx_byte` MSB first, putting each bit on SDA after the SCL falling edge that precedes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable; low clears the status and blocks replies |
| addr_1 | input | 7 | Slave address of slot 1 |
| addr_2 | input | 7 | Slave address of slot 2 |
| addr_3 | input | 7 | Slave address of slot 3 |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull | output | 1 | High pulls SDA low (acknowledge or a 0 data bit) |
| tx_byte | input | 8 | Byte sent to the master in read transfers |
| reg_rd | input | 1 | Status read strobe, acts when reg_sel is 0 |
| reg_wr | input | 1 | Control write strobe, acts when reg_sel is 1 |
| reg_sel | input | 1 | 0 selects the status word, 1 the control word |
| wr_data | input | 2 | Control write data: bit 1 lock flag, bit 0 word mode |
| buf_wr | input | 1 | Pulse for each byte written into the shared buffer |
| rd_data | output | 8 | Selected register, combinational |

## Verification
Every bus reaction arrives three clock edges after the line changes: two synchronizer flops, then the registered state update. `sda_pull` and the status flags therefore trail the master's edges by three cycles. The bench master holds every bus phase for six cycles and samples the line in the middle of each SCL high phase, well after the slave's answer has settled. `rd_data` is combinational and is sampled one time unit after the select changes. A read or write strobe takes effect at the next rising edge, so the bench pulses strobes from falling edge to falling edge and reads the effect on the following sample. The checks sweep all three slots in both directions plus an unmatched address, and compute the expected status bit position from the slot number and the direction.

// File: rtl/tri_addr_i2c_slave.sv
module tri_addr_i2c_slave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [6:0] addr_1,
  input  logic [6:0] addr_2,
  input  logic [6:0] addr_3,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  input  logic [7:0] tx_byte,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [1:0] wr_data,
  input  logic       buf_wr,
  output logic [7:0] rd_data
);
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_AACK = 3'd2, S_RX = 3'd3,
                         S_DACK = 3'd4, S_TX = 3'd5, S_MACK = 3'd6, S_HOLD = 3'd7;

  logic [2:0] scl_q, sda_q;
  logic [2:0] st;
  logic [3:0] cnt;
  logic [6:0] sh;
  logic       rw, oe, wr_seen, pend, arm, bus_busy;
  logic       nack_err, berr, busy_w, wmode, wcnt;
  logic [2:0] wf, rf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end

  logic sda, rise, fall, start_ev, stop_ev, misplaced, hw_set;
  logic [7:0] abyte;
  logic h1, h2, h3;
  logic [1:0] idx;

  assign sda       = sda_q[1];
  assign rise      = scl_q[1] & ~scl_q[2];
  assign fall      = ~scl_q[1] & scl_q[2];
  assign start_ev  = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_ev   = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  assign misplaced = (st == S_ADDR || st == S_RX || st == S_TX) && cnt > 4'd1;
  assign hw_set    = en & (start_ev | stop_ev) & wr_seen;
  assign abyte     = {sh, sda};
  assign h1        = abyte[7:1] == addr_1;
  assign h2        = abyte[7:1] == addr_2;
  assign h3        = abyte[7:1] == addr_3;
  assign idx       = h1 ? 2'd0 : (h2 ? 2'd1 : 2'd2);
  assign sda_pull  = oe;
  assign rd_data   = reg_sel ? {6'b0, busy_w, wmode} : {nack_err, berr, wf, rf};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0; oe <= 1'b0;
      wr_seen <= 1'b0; pend <= 1'b0; arm <= 1'b0; bus_busy <= 1'b0;
      nack_err <= 1'b0; berr <= 1'b0; wf <= '0; rf <= '0;
    end else if (!en) begin
      st <= S_IDLE; cnt <= '0; oe <= 1'b0;
      wr_seen <= 1'b0; pend <= 1'b0; arm <= 1'b0; bus_busy <= 1'b0;
      nack_err <= 1'b0; berr <= 1'b0; wf <= '0; rf <= '0;
    end else begin
      if (reg_rd && !reg_sel) begin
        nack_err <= 1'b0;
        berr     <= 1'b0;
        if (!bus_busy) begin
          wf <= '0;
          rf <= '0;
        end
      end
      if (start_ev || stop_ev) begin
        if (misplaced) berr <= 1'b1;
        pend     <= 1'b0;
        arm      <= 1'b0;
        wr_seen  <= 1'b0;
        oe       <= 1'b0;
        cnt      <= '0;
        st       <= start_ev ? S_ADDR : S_IDLE;
        bus_busy <= start_ev;
      end else if (rise) begin
        if (pend) begin
          arm  <= 1'b1;
          pend <= 1'b0;
        end
        case (st)
          S_ADDR: begin
            sh  <= abyte[6:0];
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              if ((h1 | h2 | h3) && !busy_w) begin
                st <= S_AACK;
                rw <= sda;
                if (sda) rf[idx] <= 1'b1;
                else begin
                  wf[idx] <= 1'b1;
                  wr_seen <= 1'b1;
                end
              end else begin
                st <= S_HOLD;
              end
            end
          end
          S_RX: begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) st <= S_DACK;
          end
          S_TX: begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) st <= S_MACK;
          end
          S_MACK: begin
            if (cnt == 4'd9) begin
              if (sda) begin
                pend <= 1'b1;
                st   <= S_HOLD;
              end else begin
                cnt <= 4'd10;
              end
            end
          end
          default: ;
        endcase
      end else if (fall) begin
        if (arm) begin
          nack_err <= 1'b1;
          arm      <= 1'b0;
        end
        case (st)
          S_AACK, S_DACK: begin
            if (cnt == 4'd8) begin
              oe  <= 1'b1;
              cnt <= 4'd9;
            end else begin
              cnt <= '0;
              if (st == S_AACK && rw) begin
                sh <= tx_byte[6:0];
                oe <= ~tx_byte[7];
                st <= S_TX;
              end else begin
                oe <= 1'b0;
                st <= S_RX;
              end
            end
          end
          S_TX: begin
            oe <= ~sh[6];
            sh <= {sh[5:0], 1'b0};
          end
          S_MACK: begin
            if (cnt == 4'd8) begin
              oe  <= 1'b0;
              cnt <= 4'd9;
            end else if (cnt == 4'd10) begin
              sh  <= tx_byte[6:0];
              oe  <= ~tx_byte[7];
              st  <= S_TX;
              cnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_w <= 1'b0;
      wmode  <= 1'b0;
      wcnt   <= 1'b0;
    end else if (hw_set) begin
      busy_w <= 1'b1;
      wcnt   <= 1'b0;
    end else if (reg_wr && reg_sel) begin
      wcnt <= 1'b0;
      if (wr_data[0] != wmode) begin
        wmode  <= wr_data[0];
        busy_w <= 1'b1;
      end else if (!wr_data[1]) begin
        busy_w <= 1'b0;
      end
    end else if (wmode && busy_w && buf_wr) begin
      if (wcnt) begin
        busy_w <= 1'b0;
        wcnt   <= 1'b0;
      end else begin
        wcnt <= 1'b1;
      end
    end
endmodule

module tri_addr_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [2:0] st,
  input logic [3:0] cnt,
  input logic       oe,
  input logic       rise,
  input logic       fall,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic [1:0] wr_data,
  input logic       wmode,
  input logic       busy_w,
  input logic       nack_err,
  input logic       berr,
  input logic [2:0] wf,
  input logic [2:0] rf,
  input logic       bus_busy
);
  localparam logic [2:0] C_ADDR = 3'd1, C_AACK = 3'd2, C_RX = 3'd3, C_DACK = 3'd4,
                         C_TX = 3'd5, C_MACK = 3'd6, C_HOLD = 3'd7;

  a_r2_pull_only_engaged: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (st == C_AACK || st == C_DACK || st == C_TX || st == C_MACK));

  a_r4_read_clears_errors: assert property (@(posedge clk) disable iff (!rst_n)
    (en && reg_rd && !reg_sel && !fall && !start_ev && !stop_ev) |=> (!nack_err && !berr));

  a_r4_busy_keeps_events: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bus_busy) |=> (((wf & $past(wf)) == $past(wf)) && ((rf & $past(rf)) == $past(rf))));

  a_r5_locked_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rise && st == C_ADDR && cnt == 4'd7 && busy_w) |=> (st == C_HOLD && !oe));

  a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && wr_data[0] == wmode && wr_data[1] && !(en && (start_ev || stop_ev)))
      |=> busy_w == $past(busy_w));

  a_r9_misplaced_sets_berr: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (start_ev || stop_ev) && (st == C_ADDR || st == C_RX || st == C_TX) && cnt > 4'd1)
      |=> berr);

  a_r10_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!oe && !nack_err && !berr && wf == 3'b0 && rf == 3'b0));
endmodule

bind tri_addr_i2c_slave tri_addr_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .st(st), .cnt(cnt), .oe(oe),
  .rise(rise), .fall(fall), .start_ev(start_ev), .stop_ev(stop_ev),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel), .wr_data(wr_data),
  .wmode(wmode), .busy_w(busy_w), .nack_err(nack_err), .berr(berr),
  .wf(wf), .rf(rf), .bus_busy(bus_busy)
);

// File: tb/tri_addr_i2c_slave_tb.sv
`timescale 1ns/1ps
module tri_addr_i2c_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull;
  logic [7:0] tx_byte = 8'h00;
  logic reg_rd = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0, buf_wr = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic [7:0] rd_data;
  logic sda_line;
  logic [6:0] adr [3];
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  assign sda_line = m_sda & ~sda_pull;
  initial begin
    adr[0] = 7'h12;
    adr[1] = 7'h35;
    adr[2] = 7'h5A;
  end

  always #2.5 clk = ~clk;

  tri_addr_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .addr_1(7'h12), .addr_2(7'h35), .addr_3(7'h5A),
    .scl_in(m_scl), .sda_in(sda_line), .sda_pull(sda_pull),
    .tx_byte(tx_byte), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .wr_data(wr_data), .buf_wr(buf_wr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step();
    repeat (6) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; m_scl = 1'b1; step();
    m_sda = 1'b0; step();
    m_scl = 1'b0; step();
  endtask

  task automatic i2c_restart();
    m_sda = 1'b1; step();
    m_scl = 1'b1; step();
    m_sda = 1'b0; step();
    m_scl = 1'b0; step();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; step();
    m_scl = 1'b1; step();
    m_sda = 1'b1; step();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; step();
    m_scl = 1'b1; step(); step();
    m_scl = 1'b0; step();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; step();
    m_scl = 1'b1; step();
    ack = ~sda_line; step();
    m_scl = 1'b0; step();
  endtask

  task automatic rbyte(output logic [7:0] v, input logic nack);
    m_sda = 1'b1;
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      step();
      m_scl = 1'b1; step();
      v = {v[6:0], sda_line}; step();
      m_scl = 1'b0; step();
    end
    send_bit(nack);
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk);
    reg_sel = 1'b0; #1 v = rd_data;
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_ctl(output logic [7:0] v);
    @(negedge clk);
    reg_sel = 1'b1; #1 v = rd_data;
    reg_sel = 1'b0;
  endtask

  task automatic ctl_wr(input logic [1:0] d);
    @(negedge clk);
    reg_sel = 1'b1; wr_data = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic buf_pulse();
    @(negedge clk); buf_wr = 1'b1;
    @(negedge clk); buf_wr = 1'b0;
  endtask

  initial begin
    logic ack;
    logic [7:0] v, got;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_status(v);   check("R1 status after reset", v, 8'h00);
    rd_ctl(v);      check("R1 control after reset", v, 8'h00);
    check("R1 sda_pull after reset", {7'b0, sda_pull}, 8'h00);

    for (int n = 0; n < 3; n++) begin
      for (int d = 0; d < 2; d++) begin
        if (d == 0) begin
          i2c_start();
          wbyte({adr[n], 1'b0}, ack); check("R2 write address ack", {7'b0, ack}, 8'h01);
          wbyte(8'h3C, ack);           check("R2 data byte ack", {7'b0, ack}, 8'h01);
          i2c_stop();
          rd_status(v); check("R3 write flag position", v, 8'h08 << n);
          rd_status(v); check("R4 idle read clears", v, 8'h00);
          rd_ctl(v);    check("R5 lock after write stop", v, 8'h02);
          ctl_wr(2'b10);
          rd_ctl(v);    check("R6 write one keeps lock", v, 8'h02);
          ctl_wr(2'b00);
          rd_ctl(v);    check("R6 write zero clears lock", v, 8'h00);
        end else begin
          tx_byte = 8'hA5 + 8'(n * 29);
          i2c_start();
          wbyte({adr[n], 1'b1}, ack); check("R2 read address ack", {7'b0, ack}, 8'h01);
          rbyte(got, 1'b1);
          check("R11 serialized byte", got, tx_byte);
          i2c_stop();
          rd_status(v); check("R3 R8 read flag, no dangling nack", v, 8'h01 << n);
          rd_status(v); check("R4 idle read clears", v, 8'h00);
          rd_ctl(v);    check("R5 read leaves lock clear", v, 8'h00);
        end
      end
    end

    i2c_start();
    wbyte({7'h40, 1'b0}, ack); check("R2 unmatched address nack", {7'b0, ack}, 8'h00);
    i2c_stop();
    rd_status(v); check("R2 unmatched sets no flag", v, 8'h00);
    rd_ctl(v);    check("R2 unmatched sets no lock", v, 8'h00);

    i2c_start(); wbyte({adr[0], 1'b0}, ack); i2c_stop();
    i2c_start();
    wbyte({adr[1], 1'b0}, ack); check("R5 locked address nack", {7'b0, ack}, 8'h00);
    i2c_stop();
    rd_status(v); check("R5 locked sets no flag", v, 8'h08);
    rd_ctl(v);    check("R5 lock held", v, 8'h02);
    ctl_wr(2'b00);
    i2c_start();
    wbyte({adr[1], 1'b0}, ack); check("R5 released address ack", {7'b0, ack}, 8'h01);
    i2c_stop();
    rd_status(v); check("R3 slot 2 write", v, 8'h10);
    ctl_wr(2'b00);

    i2c_start();
    wbyte({adr[0], 1'b0}, ack); check("R2 ack before restart", {7'b0, ack}, 8'h01);
    i2c_restart();
    wbyte({adr[1], 1'b1}, ack); check("R5 restart after write locks", {7'b0, ack}, 8'h00);
    i2c_stop();
    rd_ctl(v);    check("R5 lock after restart", v, 8'h02);
    rd_status(v); check("R9 legal restart no bus error", v, 8'h08);
    ctl_wr(2'b00);

    i2c_start();
    wbyte({adr[2], 1'b0}, ack);
    rd_status(v); check("R4 read while busy", v, 8'h20);
    rd_status(v); check("R4 busy read keeps events", v, 8'h20);
    i2c_stop();
    rd_status(v); check("R4 events after stop", v, 8'h20);
    rd_status(v); check("R4 cleared when idle", v, 8'h00);
    ctl_wr(2'b00);

    tx_byte = 8'h5E;
    i2c_start();
    wbyte({adr[0], 1'b1}, ack);
    rbyte(got, 1'b1);
    step(); m_scl = 1'b1; step(); m_scl = 1'b0; step();
    i2c_stop();
    rd_status(v); check("R8 dangling nack", v, 8'h81);
    rd_status(v); check("R4 read clears nack", v, 8'h00);

    i2c_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_restart();
    i2c_stop();
    rd_status(v); check("R9 misplaced start", v, 8'h40);
    rd_status(v); check("R4 read clears bus error", v, 8'h00);

    i2c_start(); wbyte({adr[0], 1'b0}, ack); i2c_stop();
    @(negedge clk); en = 1'b0;
    repeat (3) @(negedge clk); en = 1'b1;
    rd_status(v); check("R10 disable clears status", v, 8'h00);
    rd_ctl(v);    check("R10 lock kept", v, 8'h02);
    ctl_wr(2'b00);
    @(negedge clk); en = 1'b0;
    i2c_start();
    wbyte({adr[1], 1'b0}, ack); check("R10 disabled nack", {7'b0, ack}, 8'h00);
    i2c_stop();
    @(negedge clk); en = 1'b1;
    rd_status(v); check("R10 no flags while disabled", v, 8'h00);
    rd_ctl(v);    check("R10 no lock while disabled", v, 8'h00);

    ctl_wr(2'b01);
    rd_ctl(v); check("R6 mode change sets lock", v, 8'h03);
    @(negedge clk); reg_sel = 1'b0; wr_data = 2'b00; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd_ctl(v); check("R6 status-port write ignored", v, 8'h03);
    buf_pulse();
    rd_ctl(v); check("R7 one buffer write keeps lock", v, 8'h03);
    buf_pulse();
    rd_ctl(v); check("R7 second buffer write clears lock", v, 8'h01);
    ctl_wr(2'b00);
    rd_ctl(v); check("R6 back to byte mode sets lock", v, 8'h02);
    buf_pulse(); buf_pulse();
    rd_ctl(v); check("R7 byte mode ignores buffer writes", v, 8'h02);
    ctl_wr(2'b00);
    rd_ctl(v); check("R6 cleared", v, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule